// File: doc/BRIEF.md
# System Clock Divider and Gating Unit

This block turns one fast reference clock into synchronous clock-enable strobes for three clock groups: a CPU group, a bus group and a peripheral group. The bus group has three rates: a double-rate memory strobe, an AHB strobe and an APB strobe. Each strobe is a single-cycle pulse in the fast domain. Logic downstream uses it as a clock enable, so the block makes no derived clocks.

Every group takes its base ticks either from the reference or from its own PLL. The PLL is modelled as an input that pulses at the PLL rate. A strap input, sampled during reset, chooses the crystal or the external reference. A small write-only configuration port sets four things: the source selects, the divider fields, and one enable mask per consumer class. A divider write that would break the AHB-to-APB ratio rule is refused and raises a sticky flag. Divider and source changes are held back until the group's current period ends, so no enable period is ever truncated.

Top module: `sysclk_div_gate`

## Requirements
- R1: After reset, every mask bit is 1 and every group uses the reference. The CPU strobe runs at the reference rate. The memory and AHB strobes also run at the reference rate, the APB strobe runs at half of it, and `cfg_err` is 0.
- R2: `strap_ref` is sampled while `rst_n` is low. A value of 0 selects `ref_xtal_tick` as the reference and 1 selects `ref_ext_tick`. The choice shows on `ref_is_ext`, and later changes of the strap have no effect until the next reset.
- R3: Address 0 holds the source selects. Bit 0 is the CPU group, bit 1 the bus group and bit 2 the peripheral group. A bit value of 0 selects the reference and 1 selects that group's PLL tick input.
- R4: Address 1, bits [3:0], holds a value n. `cpu_en` pulses once every n+1 ticks of the CPU group source, so the ratio runs from 1 to 16.
- R5: `ddr_en` pulses on every bus-source tick. Address 1, bit 8, holds a value h, and `ahb_en` pulses once every h+1 bus-source ticks.
- R6: Address 1, bits [15:12], holds a value q, and `apb_en` pulses once every q+1 bus-source ticks. Every `apb_en` pulse falls in the same cycle as an `ahb_en` pulse.
- R7: An address-1 write is rejected when bit 8 is 1 and bit 12 is 0, because the APB divisor would not be a multiple of the AHB divisor. A rejected write changes no divider, and it sets `cfg_err`. `cfg_err` then stays set until reset.
- R8: Address 2 holds the AHB consumer mask, address 3 the APB mask and address 4 the peripheral mask. Consumer i sees the group strobe only while mask bit i is 1.
- R9: A new divider or CPU/bus source setting takes effect only once the group's current period has completed. No period is cut short by the change.
- R10: The peripheral strobe `per_en` follows its selected source one tick per pulse, without division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| strap_ref | input | 1 | Reference choice strap, sampled in reset |
| ref_xtal_tick | input | 1 | Crystal reference tick |
| ref_ext_tick | input | 1 | External reference tick |
| pll_cpu_tick | input | 1 | CPU group PLL tick |
| pll_bus_tick | input | 1 | Bus group PLL tick |
| pll_per_tick | input | 1 | Peripheral group PLL tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cpu_en | output | 1 | CPU group enable strobe |
| ddr_en | output | 1 | Double-rate memory enable strobe |
| ahb_en | output | 1 | AHB enable strobe |
| apb_en | output | 1 | APB enable strobe |
| per_en | output | 1 | Peripheral group enable strobe |
| ahb_clk_en | output | N_AHB | Per-consumer gated AHB strobes |
| apb_clk_en | output | N_APB | Per-consumer gated APB strobes |
| spc_clk_en | output | N_SPC | Per-consumer gated peripheral strobes |
| ref_is_ext | output | 1 | Latched reference choice |
| cfg_err | output | 1 | Sticky rejected-divider flag |

## Verification
Two events can fall in the same stretch of time: a configuration write and a pending period boundary. The bench lets the CPU strobe run at divide-by-16 and writes divide-by-1 five cycles into a period. It then checks that the next pulse arrives exactly 16 cycles after the previous one and that the one after it arrives a single cycle later. The bench also counts pulses over fixed windows, and there the AHB and APB strobes coincide on every APB pulse. Those counts show that the shared counter keeps both rates exact while a refused divider write leaves them untouched.

// File: rtl/sysclk_div_gate.sv
module sysclk_div_gate #(
  parameter int N_AHB   = 8,
  parameter int N_APB   = 8,
  parameter int N_SPC   = 4,
  parameter int DW      = 32,
  parameter int CPU_W   = 4,
  parameter int APB_W   = 4,
  parameter int AHB_BIT = 8,
  parameter int APB_LSB = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_ref,
  input  logic             ref_xtal_tick,
  input  logic             ref_ext_tick,
  input  logic             pll_cpu_tick,
  input  logic             pll_bus_tick,
  input  logic             pll_per_tick,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             cpu_en,
  output logic             ddr_en,
  output logic             ahb_en,
  output logic             apb_en,
  output logic             per_en,
  output logic [N_AHB-1:0] ahb_clk_en,
  output logic [N_APB-1:0] apb_clk_en,
  output logic [N_SPC-1:0] spc_clk_en,
  output logic             ref_is_ext,
  output logic             cfg_err
);
  localparam logic [2:0] A_SRC = 3'd0, A_DIV = 3'd1, A_GAHB = 3'd2, A_GAPB = 3'd3, A_GSPC = 3'd4;
  localparam logic [APB_W-1:0] APB_RST = APB_W'(1);

  logic [2:0]       pend_sel;
  logic [CPU_W-1:0] pend_cdiv, act_cdiv, c_cnt;
  logic             pend_h, act_h, act_csel, act_bsel;
  logic [APB_W-1:0] pend_p, act_p, b_cnt;
  logic [N_AHB-1:0] m_ahb;
  logic [N_APB-1:0] m_apb;
  logic [N_SPC-1:0] m_spc;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk)
    if (!rst_n) ref_is_ext <= strap_ref;

  wire ref_tick = ref_is_ext ? ref_ext_tick : ref_xtal_tick;
  wire div_ok   = !(cfg_wdata[AHB_BIT] && !cfg_wdata[APB_LSB]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sel  <= '0;
      pend_cdiv <= '0;
      pend_h    <= 1'b0;
      pend_p    <= APB_RST;
      m_ahb     <= '1;
      m_apb     <= '1;
      m_spc     <= '1;
      cfg_err   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_SRC:  pend_sel <= cfg_wdata[2:0];
        A_DIV:
          if (div_ok) begin
            pend_cdiv <= cfg_wdata[CPU_W-1:0];
            pend_h    <= cfg_wdata[AHB_BIT];
            pend_p    <= cfg_wdata[APB_LSB +: APB_W];
          end else cfg_err <= 1'b1;
        A_GAHB: m_ahb <= cfg_wdata[N_AHB-1:0];
        A_GAPB: m_apb <= cfg_wdata[N_APB-1:0];
        A_GSPC: m_spc <= cfg_wdata[N_SPC-1:0];
        default: ;
      endcase
    end
  end

  wire c_tick = act_csel ? pll_cpu_tick : ref_tick;
  wire c_wrap = c_tick && (c_cnt == act_cdiv);
  wire c_load = c_wrap || (!c_tick && c_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_csel <= 1'b0;
      act_cdiv <= '0;
      c_cnt    <= '0;
      cpu_en   <= 1'b0;
    end else begin
      if (c_tick) c_cnt <= c_wrap ? '0 : c_cnt + 1'b1;
      if (c_load) begin
        act_csel <= pend_sel[0];
        act_cdiv <= pend_cdiv;
      end
      cpu_en <= c_wrap;
    end
  end

  wire b_tick = act_bsel ? pll_bus_tick : ref_tick;
  wire b_wrap = b_tick && (b_cnt == act_p);
  wire b_load = b_wrap || (!b_tick && b_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_bsel <= 1'b0;
      act_h    <= 1'b0;
      act_p    <= APB_RST;
      b_cnt    <= '0;
      ddr_en   <= 1'b0;
      ahb_en   <= 1'b0;
      apb_en   <= 1'b0;
    end else begin
      if (b_tick) b_cnt <= b_wrap ? '0 : b_cnt + 1'b1;
      if (b_load) begin
        act_bsel <= pend_sel[1];
        act_h    <= pend_h;
        act_p    <= pend_p;
      end
      ddr_en <= b_tick;
      ahb_en <= b_tick && (!act_h || b_cnt[0]);
      apb_en <= b_wrap;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) per_en <= 1'b0;
    else        per_en <= pend_sel[2] ? pll_per_tick : ref_tick;

  assign ahb_clk_en = {N_AHB{ahb_en}} & m_ahb;
  assign apb_clk_en = {N_APB{apb_en}} & m_apb;
  assign spc_clk_en = {N_SPC{per_en}} & m_spc;

  a_r6_apb_on_ahb: assert property (@(posedge clk) disable iff (!rst_n) apb_en |-> ahb_en);
  a_r5_ahb_on_ddr: assert property (@(posedge clk) disable iff (!rst_n) ahb_en |-> ddr_en);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err);
  a_r7_err_cause:  assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(cfg_err) |-> $past(cfg_we && cfg_addr == A_DIV));
  a_r7_ratio_kept: assert property (@(posedge clk) disable iff (!rst_n) act_h |-> act_p[0]);
  a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $stable(ref_is_ext));
  a_r4_cpu_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                     (cpu_en && act_cdiv != '0) |=> !cpu_en);
endmodule

// File: tb/sysclk_div_gate_tb_top.sv
`timescale 1ns/1ps
module sysclk_div_gate_tb_top;
  localparam int W = 3840;
  logic clk = 0, rst_n = 0, strap_ref = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic cpu_en, ddr_en, ahb_en, apb_en, per_en, ref_is_ext, cfg_err;
  logic [7:0] ahb_clk_en, apb_clk_en;
  logic [3:0] spc_clk_en;
  int tc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0, win_go = 0;

  typedef struct { string tag; int cpu, ddr, ahb, apb, per, ga, gp, gs; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;
  always @(negedge clk) tc <= tc + 1;

  sysclk_div_gate dut_i (
    .clk(clk), .rst_n(rst_n), .strap_ref(strap_ref),
    .ref_xtal_tick(tc % 4 == 0), .ref_ext_tick(tc % 3 == 0),
    .pll_cpu_tick(1'b1), .pll_bus_tick(1'b1), .pll_per_tick(tc % 2 == 0),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cpu_en(cpu_en), .ddr_en(ddr_en), .ahb_en(ahb_en), .apb_en(apb_en), .per_en(per_en),
    .ahb_clk_en(ahb_clk_en), .apb_clk_en(apb_clk_en), .spc_clk_en(spc_clk_en),
    .ref_is_ext(ref_is_ext), .cfg_err(cfg_err));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 0; strap_ref = s;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic expect_window(string tag, int cpu, int ddr, int ahb, int apb, int per,
                               int ma, int mp, int ms);
    exp_t e;
    repeat (200) @(negedge clk);
    e.tag = tag; e.cpu = cpu; e.ddr = ddr; e.ahb = ahb; e.apb = apb; e.per = per;
    e.ga = ahb * ma; e.gp = apb * mp; e.gs = per * ms;
    sb_q.push_back(e);
    win_go = 1;
    wait (!win_go);
  endtask

  initial begin : monitor
    forever begin
      int c_cpu, c_ddr, c_ahb, c_apb, c_per, c_ga, c_gp, c_gs;
      exp_t e;
      wait (win_go);
      c_cpu = 0; c_ddr = 0; c_ahb = 0; c_apb = 0; c_per = 0; c_ga = 0; c_gp = 0; c_gs = 0;
      repeat (W) begin
        @(negedge clk);
        c_cpu += int'(cpu_en); c_ddr += int'(ddr_en); c_ahb += int'(ahb_en);
        c_apb += int'(apb_en); c_per += int'(per_en);
        c_ga += $countones(ahb_clk_en); c_gp += $countones(apb_clk_en);
        c_gs += $countones(spc_clk_en);
      end
      e = sb_q.pop_front();
      check({e.tag, " R4 cpu_en"}, c_cpu, e.cpu);
      check({e.tag, " R5 ddr_en"}, c_ddr, e.ddr);
      check({e.tag, " R5 ahb_en"}, c_ahb, e.ahb);
      check({e.tag, " R6 apb_en"}, c_apb, e.apb);
      check({e.tag, " R10 per_en"}, c_per, e.per);
      check({e.tag, " R8 ahb gates"}, c_ga, e.ga);
      check({e.tag, " R8 apb gates"}, c_gp, e.gp);
      check({e.tag, " R8 spc gates"}, c_gs, e.gs);
      win_go = 0;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int d;
    do_reset(0);
    @(negedge clk);
    check("R1 cfg_err after reset", int'(cfg_err), 0);
    check("R2 ref_is_ext strap 0", int'(ref_is_ext), 0);
    expect_window("R1 defaults xtal", 960, 960, 960, 480, 960, 8, 8, 4);

    wr(3'd0, 32'h7);
    wr(3'd1, 32'h3 | (32'h1 << 8) | (32'h3 << 12));
    wr(3'd2, 32'h05);
    wr(3'd3, 32'h80);
    wr(3'd4, 32'h0);
    expect_window("R3 pll sources", 960, 3840, 1920, 960, 1920, 2, 1, 0);

    wr(3'd1, 32'h0 | (32'h1 << 8) | (32'h2 << 12));
    @(negedge clk);
    check("R7 cfg_err on bad ratio", int'(cfg_err), 1);
    expect_window("R7 rejected write", 960, 3840, 1920, 960, 1920, 2, 1, 0);

    wr(3'd1, 32'hF | (32'h4 << 12));
    wr(3'd4, 32'hF);
    @(negedge clk);
    check("R7 cfg_err sticky", int'(cfg_err), 1);
    expect_window("R4 div16 apb5", 240, 3840, 3840, 768, 1920, 2, 1, 4);

    // R9: change CPU divide 16 -> 1 five cycles into a period
    do @(negedge clk); while (!cpu_en);
    d = 0;
    repeat (5) begin @(negedge clk); d++; end
    cfg_we = 1; cfg_addr = 3'd1; cfg_wdata = 32'h0 | (32'h4 << 12);
    @(negedge clk); d++;
    cfg_we = 0;
    while (!cpu_en) begin @(negedge clk); d++; end
    check("R9 old period completes", d, 16);
    @(negedge clk);
    check("R9 new ratio next pulse", int'(cpu_en), 1);
    expect_window("R9 cpu div1", 3840, 3840, 3840, 768, 1920, 2, 1, 4);

    wr(3'd0, 32'h5);
    @(negedge clk);
    strap_ref = 1;
    expect_window("R2 strap ignored bus bypass", 3840, 960, 960, 192, 1920, 2, 1, 4);
    check("R2 ref_is_ext held", int'(ref_is_ext), 0);

    do_reset(1);
    @(negedge clk);
    check("R1 cfg_err cleared", int'(cfg_err), 0);
    check("R2 ref_is_ext strap 1", int'(ref_is_ext), 1);
    expect_window("R1 defaults ext", 1280, 1280, 1280, 640, 1280, 8, 8, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule